// File: doc/BRIEF.md
# Processor Status Register with Flag/Write Arbitration

This block is the 8-bit status register of a small accumulator-style CPU core. It holds three arithmetic flags: zero, digit carry (a carry out of bit 3) and carry. It also holds two reset-cause flags that software can only read, time-out and power-down, and three bank-select bits that steer data-memory addressing. The register-file write port of the CPU can target it like any other register. The ALU flag-update port carries an enable and a value for each flag. Event strobes from the power-up logic, the watchdog-clear and sleep instructions, and the watchdog time-out drive the reset-cause flags.

An instruction can write this register and also update flags in the same cycle. In that case the flag port owns all three arithmetic bits. The software value for those bits is discarded. Each flag with an enable takes the ALU value, and each flag without an enable keeps its old value. The bank bits are still written. Bit-set, bit-clear, swap and move instructions present no flag enables, so their data lands in the arithmetic bits unchanged.

The ports are plain control and status pins. The write and flag ports are single-cycle strobes with no handshake, and the block accepts one of each on every clock. It never applies back-pressure. Results appear on `status_q` one clock after the inputs are sampled. The bank outputs follow the register continuously.

Top module: `cpu_status_reg`

## Requirements
- R1: `status_q` presents the bits from MSB to LSB as: indirect bank (7), bank select high (6), bank select low (5), time-out (4), power-down (3), zero (2), digit carry (1), carry (0). The flag ports use index 2 = zero, 1 = digit carry, 0 = carry.
- R2: While `rst_n` is low, bits 7..5 are 0, time-out and power-down are 1, and the three arithmetic flags are 0.
- R3: A write with `wr_en` high and `flg_en` all zero stores `wr_data` bits 7..5 and 2..0 on the next clock.
- R4: When any `flg_en` bit is high, the software write to bits 2..0 is ignored. Each enabled flag takes its `flg_val` bit, and each disabled flag holds. A simultaneous write still updates bits 7..5. A clear instruction (write 0 with only the zero enable, value 1) therefore gives 000u_u1uu.
- R5: A flag update without `wr_en` changes only the enabled flags and leaves every other bit unchanged.
- R6: Bits 4 and 3 ignore `wr_data`. They change only through the event strobes.
- R7: Time-out becomes 1 after a power-up, watchdog-clear or sleep strobe, and 0 after a watchdog time-out. When a time-out arrives together with any setting strobe, time-out reads 0.
- R8: Power-down becomes 1 after a power-up or watchdog-clear strobe, and 0 after a sleep strobe. When sleep arrives together with a setting strobe, sleep wins.
- R9: `dir_bank` equals bits 6..5 and selects the 128-byte window (00: 00h-7Fh, 01: 80h-FFh, 10: 100h-17Fh, 11: 180h-1FFh). `ind_bank` equals bit 7 and selects 00h-FFh (0) or 100h-1FFh (1).
- R10: With `HI_BANK_RESERVED` = 1, bits 7 and 6 are still stored and read back, but `ind_bank` and `dir_bank[1]` are held at 0. If software keeps those bits clear, they read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Register-file write targets this register |
| wr_data | input | 8 | Write data |
| flg_en | input | 3 | Per-flag update enables {Z, DC, C} |
| flg_val | input | 3 | Per-flag update values {Z, DC, C} |
| pwr_up | input | 1 | Power-up event strobe |
| wdt_clr | input | 1 | Watchdog-clear instruction strobe |
| sleep_cmd | input | 1 | Sleep instruction strobe |
| wdt_tmo | input | 1 | Watchdog time-out strobe |
| status_q | output | 8 | Register contents |
| dir_bank | output | 2 | Direct-addressing bank |
| ind_bank | output | 1 | Indirect-addressing bank |

## Verification
The bench targets the collision between a software write and a flag update. It checks the clear-register pattern, and it checks a full-enable update that carries write data of the opposite value. A design that let the write through would show the written flags. A design that blocked only the enabled flags would clear digit carry and carry on the clear pattern. The bench writes ones into bits 4 and 3 while they hold zeros; a design with writable reset-cause bits would read back ones. It also drives time-out with watchdog-clear, and sleep with watchdog-clear, in the same cycle; a design with the wrong priority would read 1 where 0 is expected. A second instance with the reserved parameter set shows stored high bank bits that never reach the bank outputs.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int REG_W   = 8;
  localparam int ARITH_N = 3;
  localparam int BANK_N  = 3;
  // bit positions; decoders elsewhere rely on these
  localparam int POS_C   = 0;
  localparam int POS_DC  = 1;
  localparam int POS_Z   = 2;
  localparam int POS_PD  = 3;
  localparam int POS_TO  = 4;
  localparam int POS_RP0 = 5;
  localparam int POS_RP1 = 6;
  localparam int POS_IRP = 7;
  localparam int BANK_LO = POS_RP0;

  typedef struct packed {
    logic to;
    logic pd;
  } cause_t;

  function automatic logic [REG_W-1:0] pack_status(
      input logic [BANK_N-1:0] bank, input cause_t cz, input logic [ARITH_N-1:0] ar);
    logic [REG_W-1:0] r;
    r = '0;
    r[POS_IRP:POS_RP0] = bank;
    r[POS_TO]          = cz.to;
    r[POS_PD]          = cz.pd;
    r[POS_Z:POS_C]     = ar;
    return r;
  endfunction
endpackage

// File: rtl/sreg_arith_flags.sv
module sreg_arith_flags
  import sreg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ARITH_N-1:0] wr_bits,
  input  logic [ARITH_N-1:0] upd_en,
  input  logic [ARITH_N-1:0] upd_val,
  output logic [ARITH_N-1:0] flags_q
);
  logic sw_blocked;
  assign sw_blocked = |upd_en;

  for (genvar i = 0; i < ARITH_N; i++) begin : g_flag
    logic q, nxt;
    always_comb begin
      nxt = q;
      if (upd_en[i])                 nxt = upd_val[i];
      else if (wr_en && !sw_blocked) nxt = wr_bits[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
    end
    assign flags_q[i] = q;

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_blocked && !upd_en[i]) |=> (flags_q[i] == $past(flags_q[i])));
    // R4
    flag_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en[i] |=> (flags_q[i] == $past(upd_val[i])));
    // R3
    flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !sw_blocked) |=> (flags_q[i] == $past(wr_bits[i])));
  end
endmodule

// File: rtl/sreg_reset_cause.sv
module sreg_reset_cause
  import sreg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_up,
  input  logic   wdt_clr,
  input  logic   sleep_cmd,
  input  logic   wdt_tmo,
  output cause_t cause_q
);
  cause_t nxt;
  logic   to_set, pd_set;

  assign to_set = pwr_up | wdt_clr | sleep_cmd;
  assign pd_set = pwr_up | wdt_clr;

  always_comb begin
    nxt = cause_q;
    if (wdt_tmo)     nxt.to = 1'b0;
    else if (to_set) nxt.to = 1'b1;
    if (sleep_cmd)   nxt.pd = 1'b0;
    else if (pd_set) nxt.pd = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '{to: 1'b1, pd: 1'b1};
    else        cause_q <= nxt;
  end

  // R7
  tmo_clears_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_tmo |=> !cause_q.to);
  // R7
  evt_sets_to_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_up || wdt_clr || sleep_cmd) && !wdt_tmo) |=> cause_q.to);
  // R8
  sleep_clears_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_cmd |=> !cause_q.pd);
  // R8
  evt_sets_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwr_up || wdt_clr) && !sleep_cmd) |=> cause_q.pd);
  // R6
  cause_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_up || wdt_clr || sleep_cmd || wdt_tmo) |=> $stable(cause_q));
endmodule

// File: rtl/sreg_bank_ctl.sv
module sreg_bank_ctl
  import sreg_pkg::*;
#(
  parameter bit HI_BANK_RESERVED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_N-1:0] wr_bits,
  output logic [BANK_N-1:0] bank_q,
  output logic [1:0]        dir_bank,
  output logic              ind_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank_q <= '0;
    else if (wr_en) bank_q <= wr_bits;
  end

  if (HI_BANK_RESERVED) begin : g_reserved
    assign dir_bank = {1'b0, bank_q[0]};
    assign ind_bank = 1'b0;
  end else begin : g_full
    assign dir_bank = bank_q[1:0];
    assign ind_bank = bank_q[2];
  end

  // R3
  bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bank_q == $past(wr_bits)));
  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bank_q));
  // R9
  bank_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (dir_bank[0] == $past(wr_bits[0])));
endmodule

// File: rtl/cpu_status_reg.sv
module cpu_status_reg
  import sreg_pkg::*;
#(
  parameter bit HI_BANK_RESERVED = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic [ARITH_N-1:0] flg_en,
  input  logic [ARITH_N-1:0] flg_val,
  input  logic               pwr_up,
  input  logic               wdt_clr,
  input  logic               sleep_cmd,
  input  logic               wdt_tmo,
  output logic [REG_W-1:0]   status_q,
  output logic [1:0]         dir_bank,
  output logic               ind_bank
);
  logic [ARITH_N-1:0] arith_q;
  logic [BANK_N-1:0]  bank_q;
  cause_t             cause_q;
  logic               unused_cause_bits;

  assign unused_cause_bits = ^wr_data[POS_TO:POS_PD];

  sreg_arith_flags u_arith (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_bits(wr_data[POS_Z:POS_C]),
    .upd_en(flg_en), .upd_val(flg_val), .flags_q(arith_q)
  );

  sreg_reset_cause u_cause (
    .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up), .wdt_clr(wdt_clr),
    .sleep_cmd(sleep_cmd), .wdt_tmo(wdt_tmo), .cause_q(cause_q)
  );

  sreg_bank_ctl #(.HI_BANK_RESERVED(HI_BANK_RESERVED)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_bits(wr_data[POS_IRP:BANK_LO]),
    .bank_q(bank_q), .dir_bank(dir_bank), .ind_bank(ind_bank)
  );

  assign status_q = pack_status(bank_q, cause_q, arith_q);

  // R6
  cause_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(pwr_up || wdt_clr || sleep_cmd || wdt_tmo))
      |=> (status_q[POS_TO:POS_PD] == $past(status_q[POS_TO:POS_PD])));
  // R10
  reserved_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    HI_BANK_RESERVED |-> (!ind_bank && !dir_bank[1]));
endmodule

// File: tb/tb_cpu_status_reg.sv
module tb_cpu_status_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, pwr_up = 0, wdt_clr = 0, sleep_cmd = 0, wdt_tmo = 0;
  logic [7:0] wr_data = '0;
  logic [2:0] flg_en = '0, flg_val = '0;
  logic [7:0] st, st_r;
  logic [1:0] db, db_r;
  logic ib, ib_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flg_en(flg_en),
    .flg_val(flg_val), .pwr_up(pwr_up), .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd),
    .wdt_tmo(wdt_tmo), .status_q(st), .dir_bank(db), .ind_bank(ib));

  cpu_status_reg #(.HI_BANK_RESERVED(1'b1)) dut_rsv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .flg_en(flg_en),
    .flg_val(flg_val), .pwr_up(pwr_up), .wdt_clr(wdt_clr), .sleep_cmd(sleep_cmd),
    .wdt_tmo(wdt_tmo), .status_q(st_r), .dir_bank(db_r), .ind_bank(ib_r));

  typedef struct {
    logic [7:0] st;
    logic [1:0] db;
    logic       ib;
    logic [1:0] rdb;
    logic       rib;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit done = 0, drv_done = 0;

  // reference state built from the requirements
  logic [2:0] m_ar = '0, m_bk = '0;
  logic m_to = 1, m_pd = 1;

  task automatic step(input logic we, input logic [7:0] wd, input logic [2:0] fe,
                      input logic [2:0] fv, input logic pu, input logic clr,
                      input logic slp, input logic tmo, input string req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; flg_en = fe; flg_val = fv;
    pwr_up = pu; wdt_clr = clr; sleep_cmd = slp; wdt_tmo = tmo;
    if (fe != 3'b000) begin
      for (int i = 0; i < 3; i++) if (fe[i]) m_ar[i] = fv[i];
    end else if (we) m_ar = wd[2:0];
    if (we) m_bk = wd[7:5];
    if (tmo) m_to = 1'b0; else if (pu || clr || slp) m_to = 1'b1;
    if (slp) m_pd = 1'b0; else if (pu || clr) m_pd = 1'b1;
    e.st = {m_bk, m_to, m_pd, m_ar};
    e.db = m_bk[1:0]; e.ib = m_bk[2];
    e.rdb = {1'b0, m_bk[0]}; e.rib = 1'b0;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, req);
  endtask

  // monitor: compares after each capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if ({st, db, ib} !== {e.st, e.db, e.ib}) begin
          fails++;
          $display("FAIL %s: status=%h dir=%b ind=%b expected status=%h dir=%b ind=%b",
                   e.req, st, db, ib, e.st, e.db, e.ib);
        end
        checks++;
        if ({st_r, db_r, ib_r} !== {e.st, e.rdb, e.rib}) begin
          fails++;
          $display("FAIL %s (reserved): status=%h dir=%b ind=%b expected status=%h dir=%b ind=%b",
                   e.req, st_r, db_r, ib_r, e.st, e.rdb, e.rib);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R2 reset state");
    // R1 / R3: plain write, bit positions
    step(1, 8'hA5, 3'b000, 3'b000, 0, 0, 0, 0, "R3 write A5");
    step(1, 8'h02, 3'b000, 3'b000, 0, 0, 0, 0, "R1 digit carry at bit 1");
    // R6: TO/PD ignore writes
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1, 0, "R8 sleep clears PD");
    step(1, 8'h18, 3'b000, 3'b000, 0, 0, 0, 0, "R6 write ones to TO/PD");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 1, "R7 timeout clears TO");
    step(1, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0, "R6 write FF keeps TO/PD 0");
    // R4: clear-register pattern 000u_u1uu with DC=C=1 beforehand
    step(1, 8'h00, 3'b100, 3'b100, 0, 0, 0, 0, "R4 clear pattern");
    step(1, 8'hFF, 3'b111, 3'b010, 0, 0, 0, 0, "R4 full enables override write");
    step(1, 8'h00, 3'b001, 3'b001, 0, 0, 0, 0, "R4 single enable blocks others");
    // R5: flag update without write
    step(0, 8'hFF, 3'b010, 3'b000, 0, 0, 0, 0, "R5 update DC only");
    step(0, 8'h00, 3'b101, 3'b101, 0, 0, 0, 0, "R5 update Z and C");
    // R7 / R8 event priorities
    step(0, 8'h00, 3'b000, 3'b000, 1, 0, 0, 0, "R7 power-up sets TO and PD");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 1, "R7 timeout beats clear");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 0, "R7 watchdog clear sets TO");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 1, 0, "R8 sleep beats clear");
    step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1, 1, "R7 timeout beats sleep");
    step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 0, "R8 clear sets PD");
    // R9 bank decode
    for (int b = 0; b < 8; b++)
      step(1, 8'(b << 5), 3'b000, 3'b000, 0, 0, 0, 0, "R9 bank select");
    // R10 reserved bits kept clear by software
    step(1, 8'h20, 3'b000, 3'b000, 0, 0, 0, 0, "R10 high bank bits kept clear");
    idle("R10 hold");
    drv_done = 1;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule